// File: doc/BRIEF.md
# GPIO Bank Controller with Masked Set/Clear Writes

This block controls 32 general-purpose pins, organised as two banks of 16. Each bank has eight control registers that drive the pad: output value, output enable, open-drain enable, output invert, pull-up enable, pull-down enable, input enable and input invert. A ninth register returns the synchronised level seen on each pin. The high bank (pins 16 to 31) uses the same register layout as the low bank, placed a fixed stride above it.

Software never has to read a register before changing it. Each write carries two 16-bit masks. One mask lists the pins to set and the other lists the pins to clear. Pins named in neither mask keep their value, so two agents can change different pins of one register without a read-modify-write race.

On the pad side, the block drives a value and an output enable for each pin. The output enable is gated so that a pin in open-drain mode only ever drives a low. The pull-up and pull-down controls go straight to the pad cell.

Top module: `gpio_sc_top`

## Requirements
- R1: After reset every control register is 0. Reading any control register returns 0xFFFF0000, `pad_oe` is all zeros, and the level register reads 0.
- R2: Pins 0–15 are reached at bank offset 0x00 and pins 16–31 at offset 0x80. A write to one bank leaves the other bank unchanged. The control registers within a bank are at these offsets:
  - 0x00 output value
  - 0x04 output enable
  - 0x08 open-drain enable
  - 0x0C output invert
  - 0x18 pull-up enable
  - 0x1C pull-down enable
  - 0x20 input enable
  - 0x24 input invert
- R3: On a write, `wr_data` bit n (0–15) set to 1 sets the control bit of pin n, and bit n+16 set to 1 clears it. A pin whose two bits are both 0 keeps its value. The write takes effect at the clock edge on which `wr_en` is high.
- R4: If a write has both bit n and bit n+16 at 1, the control bit for pin n ends at 0.
- R5: Reading a control register returns the 16 current bits in `rd_data[15:0]` and their complements in `rd_data[31:16]`. The read is combinational from `addr`.
- R6: `pad_out` for each pin equals the output value XOR the output invert bit.
- R7: `pad_oe` for each pin equals output enable AND (NOT open-drain OR NOT `pad_out`). An open-drain pin therefore drives only lows.
- R8: `pull_up` and `pull_dn` reflect the pull-up enable and pull-down enable bits of each pin.
- R9: The level register (bank offset 0x30) returns `pad_in` after a two-flop synchroniser, XOR the input invert bit, AND the input enable bit, in bits 15:0, with bits 31:16 at 0. A change on `pad_in` is visible after the second rising edge.
- R10: Writes to the level register, to unmapped offsets, or to any address that is not a multiple of 4 change no state. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address; bit 7 selects the bank |
| wr_data | input | 32 | Set mask in bits 15:0, clear mask in bits 31:16 |
| rd_data | output | 32 | Read data for `addr` |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Value driven to each pad |
| pad_oe | output | 32 | Pad output enable |
| pull_up | output | 32 | Pull-up enable for each pad |
| pull_dn | output | 32 | Pull-down enable for each pad |

## Verification
Random writes, each with independently random set and clear masks, go to randomly chosen registers in both banks. These writes mix four cases for every pin in a single transfer: set only, clear only, both, and neither. This separates correct merge behaviour from a plain overwrite, from set-wins priority, and from cross-bank aliasing.

Directed patterns cover the following cases:
- all-ones masks, which check clear priority;
- writes to unmapped and misaligned addresses, which must leave all state unchanged;
- a step on `pad_in` sampled one edge and two edges later, which pins down the synchroniser depth.

Each pad output is compared against a model after every write. Open-drain and invert combinations therefore exercise every row of the enable gating.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  typedef enum logic [2:0] {
    K_OUT_VAL, K_OUT_EN, K_OD_EN, K_OUT_INV,
    K_PULL_UP, K_PULL_DN, K_IN_EN, K_IN_INV
  } ctlKind_e;

  localparam int NUM_KINDS = 8;

  typedef struct packed {
    logic     wr;      // write qualified by a mapped control register
    logic     bank;    // 0 = low pins, 1 = high pins
    logic     ctlHit;  // address selects a control register
    logic     rbHit;   // address selects the level register
    ctlKind_e kind;
  } busStrobe_t;
endpackage

// File: rtl/gpio_sc_ctrl.sv
module gpio_sc_ctrl
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output busStrobe_t        stb
);
  localparam int OFF_W = ADDR_W - 1;

  logic [OFF_W-1:0] offset;
  assign offset = addr[OFF_W-1:0];

  always_comb begin
    stb        = '0;
    stb.bank   = addr[ADDR_W-1];
    stb.kind   = K_OUT_VAL;
    stb.ctlHit = 1'b1;
    unique case (offset)
      OFF_W'('h00): stb.kind = K_OUT_VAL;
      OFF_W'('h04): stb.kind = K_OUT_EN;
      OFF_W'('h08): stb.kind = K_OD_EN;
      OFF_W'('h0C): stb.kind = K_OUT_INV;
      OFF_W'('h18): stb.kind = K_PULL_UP;
      OFF_W'('h1C): stb.kind = K_PULL_DN;
      OFF_W'('h20): stb.kind = K_IN_EN;
      OFF_W'('h24): stb.kind = K_IN_INV;
      OFF_W'('h30): begin stb.ctlHit = 1'b0; stb.rbHit = 1'b1; end
      default:      stb.ctlHit = 1'b0;
    endcase
    stb.wr = wr_en & stb.ctlHit;
  end
endmodule

// File: rtl/gpio_sc_datapath.sv
module gpio_sc_datapath
  import gpio_sc_pkg::*;
#(
  parameter int PINS_PER_BANK = 16,
  parameter int NUM_BANKS     = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  busStrobe_t                              stb,
  input  logic [2*PINS_PER_BANK-1:0]              wr_data,
  output logic [2*PINS_PER_BANK-1:0]              rd_data,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0]      pad_in,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]      pad_out,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]      pad_oe,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]      pull_up,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]      pull_dn
);
  localparam int P = PINS_PER_BANK;

  logic [NUM_BANKS-1:0][NUM_KINDS-1:0][P-1:0] ctlQ;
  logic [NUM_BANKS-1:0][SYNC_STAGES-1:0][P-1:0] syncQ;
  logic [NUM_BANKS-1:0][P-1:0] levelBank;
  logic [P-1:0] setMask, clrMask;

  assign setMask = wr_data[P-1:0];
  assign clrMask = wr_data[2*P-1:P];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlQ <= '0;
    end else if (stb.wr) begin
      ctlQ[stb.bank][stb.kind] <= (ctlQ[stb.bank][stb.kind] | setMask) & ~clrMask;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [P-1:0] drive;
    assign drive = ctlQ[b][K_OUT_VAL] ^ ctlQ[b][K_OUT_INV];
    assign pad_out[b*P +: P] = drive;
    assign pad_oe[b*P +: P]  = ctlQ[b][K_OUT_EN] & (~ctlQ[b][K_OD_EN] | ~drive);
    assign pull_up[b*P +: P] = ctlQ[b][K_PULL_UP];
    assign pull_dn[b*P +: P] = ctlQ[b][K_PULL_DN];

    always_ff @(posedge clk) begin
      if (!rst_n) syncQ[b] <= '0;
      else        syncQ[b] <= {syncQ[b][SYNC_STAGES-2:0], pad_in[b*P +: P]};
    end
    assign levelBank[b] = (syncQ[b][SYNC_STAGES-1] ^ ctlQ[b][K_IN_INV]) & ctlQ[b][K_IN_EN];

    // R7
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[b*P +: P] & ctlQ[b][K_OD_EN] & pad_out[b*P +: P]) == '0);
    // R7
    oe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[b*P +: P] & ~ctlQ[b][K_OUT_EN]) == '0);
    // R9
    level_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (levelBank[b] & ~ctlQ[b][K_IN_EN]) == '0);
  end

  always_comb begin
    if (stb.ctlHit)     rd_data = {~ctlQ[stb.bank][stb.kind], ctlQ[stb.bank][stb.kind]};
    else if (stb.rbHit) rd_data = {{P{1'b0}}, levelBank[stb.bank]};
    else                rd_data = '0;
  end

  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wr |=> (ctlQ[$past(stb.bank)][$past(stb.kind)] & $past(setMask & clrMask)) == '0);
  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.wr |=> $stable(ctlQ));
  // R3
  set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wr |=> ((ctlQ[$past(stb.bank)][$past(stb.kind)] & $past(setMask & ~clrMask))
                == $past(setMask & ~clrMask)));
endmodule

// File: rtl/gpio_sc_top.sv
module gpio_sc_top
  import gpio_sc_pkg::*;
#(
  parameter int PINS_PER_BANK = 16,
  parameter int ADDR_W        = 8,
  localparam int NPINS        = 2 * PINS_PER_BANK,
  localparam int DW           = 2 * PINS_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pull_up,
  output logic [NPINS-1:0]  pull_dn
);
  busStrobe_t stb;

  gpio_sc_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .wr_en (wr_en),
    .addr  (addr),
    .stb   (stb)
  );

  gpio_sc_datapath #(.PINS_PER_BANK(PINS_PER_BANK), .NUM_BANKS(2), .SYNC_STAGES(2)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pull_up (pull_up),
    .pull_dn (pull_dn)
  );
endmodule

// File: tb/gpio_sc_top_tb.sv
module gpio_sc_top_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data, pad_in = 0, pad_out, pad_oe, pull_up, pull_dn;
  int nTests = 0, nFail = 0;
  logic [15:0] m [2][8];

  always #2 clk = ~clk;

  gpio_sc_top dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up(pull_up), .pull_dn(pull_dn));

  function automatic logic [7:0] kindOff(int k);
    case (k)
      0: return 8'h00; 1: return 8'h04; 2: return 8'h08; 3: return 8'h0C;
      4: return 8'h18; 5: return 8'h1C; 6: return 8'h20; default: return 8'h24;
    endcase
  endfunction

  function automatic logic [31:0] expDrive();
    return {m[1][0] ^ m[1][3], m[0][0] ^ m[0][3]};
  endfunction

  function automatic logic [31:0] expOe();
    logic [31:0] d = expDrive();
    return {m[1][1], m[0][1]} & (~{m[1][2], m[0][2]} | ~d);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic readChk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rd_data, exp);
  endtask

  task automatic scanAll(string req);
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 8; k++)
        readChk(req, kindOff(k) | (b ? 8'h80 : 8'h00), {~m[b][k], m[b][k]});
    check("R6", pad_out, expDrive());
    check("R7", pad_oe, expOe());
    check("R8", pull_up, {m[1][4], m[0][4]});
    check("R8", pull_dn, {m[1][5], m[0][5]});
  endtask

  task automatic modelWrite(int b, int k, logic [31:0] d);
    m[b][k] = (m[b][k] | d[15:0]) & ~d[31:16];
    doWrite(kindOff(k) | (b ? 8'h80 : 8'h00), d);
  endtask

  initial begin
    #400000; nFail++; $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail); $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < 2; b++) for (int k = 0; k < 8; k++) m[b][k] = '0;
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 reset state
    scanAll("R1");
    readChk("R1", 8'h30, 32'h0);
    check("R1", pad_oe, 32'h0);
    // R2 bank independence, R3 set/clear, R5 read format
    modelWrite(0, 0, 32'h0000_A5A5); scanAll("R2");
    modelWrite(1, 0, 32'h0000_00FF); scanAll("R3");
    modelWrite(0, 0, 32'h0005_0000); scanAll("R3");
    // R4 clear wins when both bits set
    modelWrite(1, 0, 32'hFFFF_FFFF); scanAll("R4");
    readChk("R4", 8'h80, 32'hFFFF_0000);
    // R10 ignored writes: unmapped, misaligned, level register
    doWrite(8'h10, 32'h0000_FFFF); doWrite(8'h01, 32'h0000_FFFF);
    doWrite(8'h30, 32'h0000_FFFF); doWrite(8'hB4, 32'h0000_FFFF);
    scanAll("R10");
    readChk("R10", 8'h14, 32'h0);
    readChk("R10", 8'h02, 32'h0);
    // R7 open-drain: drive 1 in OD -> oe low; drive 0 -> oe high
    modelWrite(0, 1, 32'h0000_000F); modelWrite(0, 2, 32'h0000_0003);
    modelWrite(0, 0, 32'h0000_0005); scanAll("R7");
    modelWrite(0, 3, 32'h0000_0001); scanAll("R6");
    // random mix
    for (int i = 0; i < 300; i++) begin
      int b = $urandom_range(1, 0);
      int k = $urandom_range(7, 0);
      modelWrite(b, k, $urandom());
      if (i % 20 == 0) scanAll("R3");
    end
    scanAll("R5");
    // R9 level path with synchroniser latency
    modelWrite(0, 6, 32'hFFFF_0000); modelWrite(1, 6, 32'hFFFF_0000);
    modelWrite(0, 7, 32'hFFFF_0000); modelWrite(1, 7, 32'hFFFF_0000);
    modelWrite(0, 6, 32'h0000_F0F0); modelWrite(1, 6, 32'h0000_FFFF);
    modelWrite(1, 7, 32'h0000_00FF);
    @(negedge clk); pad_in = 32'h1234_ABCD; addr = 8'h30;
    @(negedge clk); #1; check("R9", rd_data, 32'h0);
    @(negedge clk); #1; check("R9", rd_data, {16'h0, 16'hABCD & 16'hF0F0});
    addr = 8'hB0; #1; check("R9", rd_data, {16'h0, 16'h1234 ^ 16'h00FF});
    @(negedge clk); pad_in = 32'h0;
    repeat (2) @(negedge clk); #1; check("R9", rd_data, {16'h0, 16'h00FF});
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule